// File: doc/BRIEF.md
# Indirect Load/Store Address Generator

This block forms the memory address for loads and stores whose address comes from a register. It also advances the base register in the auto-modify modes. The base comes from a small local register file. That file holds eight general registers and a stack pointer, and a write port and a read port let the file be loaded and inspected. A start strobe supplies four things: a base selector, a transfer size, an addressing mode and a store flag.

On the clock edge where start is high, the block does four things:
- It computes the access address.
- It checks that address for alignment.
- It registers a memory request with byte-lane enables.
- It writes the updated base back into the register file when the mode asks for it.

The request, exception and write-back indications are single-cycle pulses. Address, lanes and write-back value stay as they are until the next start. Load data returned on the memory read bus is extracted from the addressed lanes and extended to register width. The extension is signed or unsigned, as the transfer size dictates.

Top module: `ind_addr_gen`

## Requirements
- R1: Selector codes 0 to 7 pick general registers r0 to r7, and every code of 8 or more picks the stack pointer. The same mapping applies to the write port, the read port and the base selector. A write through the write port is visible on the read port in the next cycle.
- R2: Transfer size codes are 0 = signed byte, 1 = unsigned byte, 2 = 16-bit and 3 = 24-bit. The base step for these codes is 1, 1, 2 and 4 respectively. All base arithmetic wraps modulo 2^24.
- R3: Mode code 0 is plain indirect. The access address equals the base and the base register is left unchanged (wb_en stays 0).
- R4: Mode code 1 is post-increment and mode code 2 is post-decrement. The access uses the unmodified base, and the base register then becomes base + step or base - step.
- R5: Mode code 3 is pre-decrement. Both the access address and the new base register value equal base - step.
- R6: A 16-bit access whose address has bit 0 set is misaligned. A 24-bit access whose address has either of bits 1:0 set is also misaligned. The check uses the final access address, so in pre-decrement it uses the decremented value. A misaligned access pulses misalign and produces no mem_req, no mem_we, no wb_en and no register change.
- R7: The byte-lane enables depend on the transfer size. A byte access enables lane addr[1:0] only. A 16-bit access enables lanes 1:0 when addr[1] = 0 and lanes 3:2 when addr[1] = 1. A 24-bit access enables lanes 2:0. mem_we equals the store flag on a request.
- R8: load_value is taken from the address and size of the last started access. A byte is read from bits 8*addr[1:0] of mem_rdata, and is sign-extended for code 0 and zero-extended for code 1. A 16-bit value is read from bits 16*addr[1] and zero-extended. A 24-bit value is mem_rdata[23:0].
- R9: The mem_req, mem_we, wb_en and misalign outputs pulse for exactly the one cycle after a start edge. They are 0 after any edge without start.
- R10: After synchronous active-low reset, all registers read 0 and no request, write-back or exception is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_we | input | 1 | Register file write strobe |
| rf_wsel | input | 4 | Register file write selector |
| rf_wdata | input | 24 | Register file write data |
| rf_rsel | input | 4 | Register file read selector |
| rf_rdata | output | 24 | Register file read data |
| start | input | 1 | Start an indirect access |
| base_sel | input | 4 | Base register selector |
| xfer_size | input | 2 | Transfer size code |
| addr_mode | input | 2 | Addressing mode code |
| is_store | input | 1 | Access is a store |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Memory write pulse |
| mem_addr | output | 24 | Access address |
| mem_be | output | 4 | Byte-lane enables |
| mem_rdata | input | 32 | Memory read data |
| load_value | output | 24 | Extended load result |
| wb_en | output | 1 | Base write-back pulse |
| wb_sel | output | 4 | Written register index (8 = stack pointer) |
| wb_value | output | 24 | Base write-back value |
| misalign | output | 1 | Misaligned access exception pulse |

## Verification
The bench builds the block with its default parameters: 24-bit addresses and eight general registers plus the stack pointer. At this size every combination of selector (including an alias code above 8), size, mode and store flag can be swept. The sweep runs across base values chosen for their low two bits and for wrap-around at both ends of the 24-bit space. Those values reach every alignment outcome, every lane pattern, and wrap in both directions. Each aligned load is also checked for extension against read patterns with the lane sign bits set and clear.

// File: rtl/ind_agu_pkg.sv
// Shared types for the indirect address generator.
// Assumes a 4-lane (32-bit) memory data bus.
package ind_agu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE_S = 2'd0,
        SZ_BYTE_U = 2'd1,
        SZ_HALF   = 2'd2,
        SZ_WIDE   = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        M_PLAIN   = 2'd0,
        M_POSTINC = 2'd1,
        M_POSTDEC = 2'd2,
        M_PREDEC  = 2'd3
    } addr_mode_e;

    // Base step in bytes for a transfer size.
    function automatic logic [2:0] step_of(xfer_size_e sz);
        case (sz)
            SZ_HALF: return 3'd2;
            SZ_WIDE: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/ind_agu_regfile.sv
// Register file of NGPR general registers plus one stack pointer at index NGPR.
// One external write port, one internal write-back port (priority) and two
// combinational read ports. Indices are pre-mapped by the caller.
module ind_agu_regfile #(
    parameter int AW   = 24,
    parameter int NGPR = 8,
    localparam int NREG = NGPR + 1,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_we,
    input  logic [SELW-1:0] ext_idx,
    input  logic [AW-1:0]   ext_data,
    input  logic            wb_we,
    input  logic [SELW-1:0] wb_idx,
    input  logic [AW-1:0]   wb_data,
    input  logic [SELW-1:0] rd_a_idx,
    output logic [AW-1:0]   rd_a_data,
    input  logic [SELW-1:0] rd_b_idx,
    output logic [AW-1:0]   rd_b_data
);
    logic [AW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Per-register update: write-back beats the external port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wb_we && wb_idx == SELW'(g))
                regs[g] <= wb_data;
            else if (ext_we && ext_idx == SELW'(g))
                regs[g] <= ext_data;
        end
    end

    // Read ports; callers guarantee indices below NREG.
    always_comb begin
        rd_a_data = regs[rd_a_idx];
        rd_b_data = regs[rd_b_idx];
    end
endmodule

// File: rtl/ind_agu_calc.sv
// Combinational address arithmetic: access address, write-back value,
// alignment check and byte-lane enables for one indirect access.
// Assumes AW >= 2; arithmetic wraps modulo 2^AW.
module ind_agu_calc
    import ind_agu_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] base,
    input  xfer_size_e    size,
    input  addr_mode_e    mode,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] wb_value,
    output logic          wb_need,
    output logic          misalign,
    output logic [3:0]    lane_en
);
    logic [AW-1:0] step;
    logic [AW-1:0] up;
    logic [AW-1:0] dn;

    // Step, incremented and decremented base.
    always_comb begin
        step = AW'(step_of(size));
        up   = base + step;
        dn   = base - step;
    end

    // Mode selects address source and write-back value.
    always_comb begin
        case (mode)
            M_POSTINC: begin eff_addr = base; wb_value = up;   wb_need = 1'b1; end
            M_POSTDEC: begin eff_addr = base; wb_value = dn;   wb_need = 1'b1; end
            M_PREDEC:  begin eff_addr = dn;   wb_value = dn;   wb_need = 1'b1; end
            default:   begin eff_addr = base; wb_value = base; wb_need = 1'b0; end
        endcase
    end

    // Alignment check and lane enables on the final address.
    always_comb begin
        case (size)
            SZ_HALF: begin
                misalign = eff_addr[0];
                lane_en  = eff_addr[1] ? 4'b1100 : 4'b0011;
            end
            SZ_WIDE: begin
                misalign = |eff_addr[1:0];
                lane_en  = 4'b0111;
            end
            default: begin
                misalign = 1'b0;
                lane_en  = 4'b0001 << eff_addr[1:0];
            end
        endcase
    end
endmodule

// File: rtl/ind_agu_lane.sv
// Load data extraction: picks the addressed lanes from the 32-bit read bus
// and extends to AW bits. Assumes AW >= 16.
module ind_agu_lane
    import ind_agu_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [31:0]   rdata,
    input  xfer_size_e    size,
    input  logic [1:0]    lo,
    output logic [AW-1:0] value
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    // Lane selection.
    always_comb begin
        byte_v = rdata[8*lo +: 8];
        half_v = lo[1] ? rdata[31:16] : rdata[15:0];
    end

    // Extension by size.
    always_comb begin
        case (size)
            SZ_BYTE_S: value = {{(AW-8){byte_v[7]}}, byte_v};
            SZ_BYTE_U: value = {{(AW-8){1'b0}}, byte_v};
            SZ_HALF:   value = {{(AW-16){1'b0}}, half_v};
            default:   value = AW'(rdata[23:0]);
        endcase
    end
endmodule

// File: rtl/ind_addr_gen.sv
// Indirect load/store address generator. On a start edge, reads the selected
// base, forms the access address, checks alignment, registers the memory
// request and writes the modified base back. Selector codes >= NGPR map to SP.
module ind_addr_gen
    import ind_agu_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NGPR = 8,
    localparam int NREG = NGPR + 1,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rf_we,
    input  logic [SELW-1:0] rf_wsel,
    input  logic [AW-1:0]   rf_wdata,
    input  logic [SELW-1:0] rf_rsel,
    output logic [AW-1:0]   rf_rdata,
    input  logic            start,
    input  logic [SELW-1:0] base_sel,
    input  logic [1:0]      xfer_size,
    input  logic [1:0]      addr_mode,
    input  logic            is_store,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [3:0]      mem_be,
    input  logic [31:0]     mem_rdata,
    output logic [AW-1:0]   load_value,
    output logic            wb_en,
    output logic [SELW-1:0] wb_sel,
    output logic [AW-1:0]   wb_value,
    output logic            misalign
);
    localparam logic [SELW-1:0] SP_IDX = SELW'(NGPR);

    // Map a selector code to a register index.
    function automatic logic [SELW-1:0] map_idx(logic [SELW-1:0] s);
        return (s >= SP_IDX) ? SP_IDX : s;
    endfunction

    xfer_size_e    size_in, size_q;
    addr_mode_e    mode_in, mode_q;
    logic [SELW-1:0] base_idx;
    logic [AW-1:0] base_val;
    logic [AW-1:0] eff_addr, wbv;
    logic          wb_need, mis;
    logic [3:0]    lanes;
    logic          wb_now;

    // Input decode.
    always_comb begin
        size_in  = xfer_size_e'(xfer_size);
        mode_in  = addr_mode_e'(addr_mode);
        base_idx = map_idx(base_sel);
        wb_now   = start && wb_need && !mis;
    end

    ind_agu_regfile #(.AW(AW), .NGPR(NGPR)) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_we    (rf_we),
        .ext_idx   (map_idx(rf_wsel)),
        .ext_data  (rf_wdata),
        .wb_we     (wb_now),
        .wb_idx    (base_idx),
        .wb_data   (wbv),
        .rd_a_idx  (base_idx),
        .rd_a_data (base_val),
        .rd_b_idx  (map_idx(rf_rsel)),
        .rd_b_data (rf_rdata)
    );

    ind_agu_calc #(.AW(AW)) calc_i (
        .base     (base_val),
        .size     (size_in),
        .mode     (mode_in),
        .eff_addr (eff_addr),
        .wb_value (wbv),
        .wb_need  (wb_need),
        .misalign (mis),
        .lane_en  (lanes)
    );

    // Pulse outputs: set for the one cycle after a start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            wb_en    <= 1'b0;
            misalign <= 1'b0;
        end else begin
            mem_req  <= start && !mis;
            mem_we   <= start && !mis && is_store;
            wb_en    <= wb_now;
            misalign <= start && mis;
        end
    end

    // Held access descriptors, refreshed on each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_be   <= '0;
            wb_value <= '0;
            wb_sel   <= '0;
            size_q   <= SZ_BYTE_S;
            mode_q   <= M_PLAIN;
        end else if (start) begin
            mem_addr <= eff_addr;
            mem_be   <= lanes;
            wb_value <= wbv;
            wb_sel   <= base_idx;
            size_q   <= size_in;
            mode_q   <= mode_in;
        end
    end

    ind_agu_lane #(.AW(AW)) lane_i (
        .rdata (mem_rdata),
        .size  (size_q),
        .lo    (mem_addr[1:0]),
        .value (load_value)
    );

    // Misalignment suppresses request and write-back.
    assert_mis_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_req && !mem_we && !wb_en));

    // Plain mode never writes the base back.
    assert_plain_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mode_q == M_PLAIN) |-> !wb_en);

    // Post-increment: new base is address plus step.
    assert_postinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mode_q == M_POSTINC) |-> (wb_en && wb_value == mem_addr + AW'(step_of(size_q))));

    // Pre-decrement: new base equals the access address.
    assert_predec_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mode_q == M_PREDEC) |-> (wb_en && wb_value == mem_addr));

    // 16-bit requests enable exactly two lanes, aligned.
    assert_half_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && size_q == SZ_HALF) |-> ($countones(mem_be) == 2 && !mem_addr[0]));

    // No pulse without a start on the previous edge.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!mem_req && !wb_en && !misalign && !mem_we));
endmodule

// File: tb/ind_addr_gen_tb_top.sv
module ind_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_wsel = '0;
    logic [23:0] rf_wdata = '0;
    logic [3:0]  rf_rsel = '0;
    logic [23:0] rf_rdata;
    logic        start = 1'b0;
    logic [3:0]  base_sel = '0;
    logic [1:0]  xfer_size = '0;
    logic [1:0]  addr_mode = '0;
    logic        is_store = 1'b0;
    logic        mem_req, mem_we, wb_en, misalign;
    logic [23:0] mem_addr, load_value, wb_value;
    logic [3:0]  mem_be, wb_sel;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ind_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_wsel(rf_wsel),
        .rf_wdata(rf_wdata), .rf_rsel(rf_rsel), .rf_rdata(rf_rdata),
        .start(start), .base_sel(base_sel), .xfer_size(xfer_size),
        .addr_mode(addr_mode), .is_store(is_store), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .load_value(load_value), .wb_en(wb_en),
        .wb_sel(wb_sel), .wb_value(wb_value), .misalign(misalign)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] lane_ext(input logic [31:0] rd, input int sz, input logic [1:0] lo);
        logic [7:0]  b;
        logic [15:0] h;
        b = rd[8*lo +: 8];
        h = lo[1] ? rd[31:16] : rd[15:0];
        if (sz == 0) return {{16{b[7]}}, b};
        if (sz == 1) return {16'h0, b};
        if (sz == 2) return {8'h0, h};
        return rd[23:0];
    endfunction

    task automatic run_op(input int sel, input int sz, input int md, input logic [23:0] base, input bit st);
        logic [23:0] step, addr, wbv, fin;
        logic [3:0]  be;
        bit mis, wbe;
        logic [31:0] pats [2];
        pats[0] = 32'h80FF7F01;
        pats[1] = 32'h7F0180FE;
        step = (sz < 2) ? 24'd1 : (sz == 2 ? 24'd2 : 24'd4);
        addr = (md == 3) ? base - step : base;
        wbv  = (md == 1) ? base + step : (md == 0 ? base : base - step);
        mis  = (sz == 2 && addr[0]) || (sz == 3 && addr[1:0] != 2'b00);
        wbe  = !mis && md != 0;
        fin  = wbe ? wbv : base;
        if (sz < 2) be = 4'b0001 << addr[1:0];
        else if (sz == 2) be = addr[1] ? 4'b1100 : 4'b0011;
        else be = 4'b0111;
        // preload base through write port (R1)
        @(negedge clk);
        rf_we = 1'b1; rf_wsel = 4'(sel); rf_wdata = base;
        @(negedge clk);
        rf_we = 1'b0;
        start = 1'b1; base_sel = 4'(sel); xfer_size = 2'(sz); addr_mode = 2'(md); is_store = st;
        @(negedge clk);
        start = 1'b0;
        rf_rsel = 4'(sel);
        #1;
        check("R6 misalign", 32'(misalign), 32'(mis));
        check("R6 mem_req", 32'(mem_req), 32'(!mis));
        check("R7 mem_we", 32'(mem_we), 32'(!mis && st));
        check("R3/R4/R5 wb_en", 32'(wb_en), 32'(wbe));
        if (!mis) begin
            check("R3/R4/R5 mem_addr", 32'(mem_addr), 32'(addr));
            check("R7 mem_be", 32'(mem_be), 32'(be));
        end
        if (wbe) begin
            check("R4/R5 wb_value R2", 32'(wb_value), 32'(wbv));
            check("R1 wb_sel", 32'(wb_sel), (sel >= 8) ? 32'd8 : 32'(sel));
        end
        check("R1 base register after op", 32'(rf_rdata), 32'(fin));
        if (!mis && !st) begin
            for (int p = 0; p < 2; p++) begin
                mem_rdata = pats[p];
                #1;
                check("R8 load_value", 32'(load_value), 32'(lane_ext(pats[p], sz, addr[1:0])));
            end
        end
        @(negedge clk);
        check("R9 quiet after pulse", {28'h0, mem_req, mem_we, wb_en, misalign}, 32'h0);
    endtask

    initial begin
        logic [23:0] bases [12];
        bases[0] = 24'h000000; bases[1] = 24'h000001; bases[2] = 24'h000002;
        bases[3] = 24'h000003; bases[4] = 24'h000005; bases[5] = 24'h000006;
        bases[6] = 24'h000007; bases[7] = 24'hFFFFFF; bases[8] = 24'hFFFFFE;
        bases[9] = 24'hFFFFFC; bases[10] = 24'h123456; bases[11] = 24'h800001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        check("R10 outputs after reset", {28'h0, mem_req, mem_we, wb_en, misalign}, 32'h0);
        for (int r = 0; r < 9; r++) begin
            rf_rsel = 4'(r);
            #1;
            check("R10 register after reset", 32'(rf_rdata), 32'h0);
        end
        // R1: SP alias and isolation between r3 and SP
        @(negedge clk);
        rf_we = 1'b1; rf_wsel = 4'd15; rf_wdata = 24'hABCDEF;
        @(negedge clk);
        rf_we = 1'b1; rf_wsel = 4'd3; rf_wdata = 24'h000111;
        @(negedge clk);
        rf_we = 1'b0; rf_rsel = 4'd8;
        #1;
        check("R1 SP via alias code", 32'(rf_rdata), 32'hABCDEF);
        rf_rsel = 4'd3;
        #1;
        check("R1 r3 write", 32'(rf_rdata), 32'h000111);
        // main sweep
        for (int sel = 0; sel < 10; sel++)
            for (int sz = 0; sz < 4; sz++)
                for (int md = 0; md < 4; md++)
                    for (int b = 0; b < 12; b++)
                        run_op(sel, sz, md, bases[b], bit'((b + md) & 1));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule